// File: doc/BRIEF.md
# Passive SPI Word Monitor

This block listens to a four-wire SPI bus without driving any line. It samples the serial clock, the two data lines and the chip select with a faster system clock, then rebuilds the words moving in both directions at the same time. Runtime inputs choose the clock polarity and phase, the bit order, the chip-select polarity and the word length.

Each time a word completes, the block raises a one-cycle strobe. The strobe carries the controller-to-peripheral word, the peripheral-to-controller word, and the values of a free-running sample counter taken when the first bit and the last bit of the word were captured. A running total of completed words is also kept. Typical use is as a probe inside a larger chip or test harness, where its word strobes feed a trace path or a checker.

Top module: `spi_mon`

## Requirements
- R1: After synchronous reset, `word_valid` is 0, and `word_count`, `word_mosi`, `word_miso`, `word_t_first` and `word_t_last` are all zero.
- R2: Bits are captured only when the synchronised clock level differs from its level in the previous sample. With `cfg_cpol == cfg_cpha` (modes 0 and 3) a capture happens on a low-to-high change. With `cfg_cpol != cfg_cpha` (modes 1 and 2) it happens on a high-to-low change. Changes in the other direction and changes on the data lines alone capture nothing.
- R3: With `cfg_lsb_first` = 0, the k-th captured bit of a word (k counted from 0) lands at bit position L-1-k, where L is the word length.
- R4: With `cfg_lsb_first` = 1, the k-th captured bit lands at bit position k.
- R5: MOSI and MISO are captured on the same clock change, each into its own word.
- R6: The word length is L = `cfg_len_m1` + 1, which gives 1 to 32 bits. When the L-th bit is captured, `word_valid` is high for exactly one cycle, starting on the clock after the capture cycle. Bits above L-1 read as zero.
- R7: A 32-bit sample counter starts at 0 in the first cycle after reset and adds 1 every cycle. `word_t_first` holds its value in the cycle the word's first bit was captured, and `word_t_last` holds its value in the cycle the last bit was captured.
- R8: `word_count` goes up by 1 in the same cycle that `word_valid` is high, and it wraps at its width. After a word, the next capture starts a new word at bit index 0.
- R9: The chip select is active when its synchronised level equals `cfg_cs_active_high`. While it is inactive, the partial word and the bit index are cleared and clock changes capture nothing, so an interrupted word is never reported.
- R10: Every bus input goes through a two-stage synchroniser. A bit is captured on the second clock after the one that first registers the bus change, so a word's `word_valid` appears on the third clock after that change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the bus |
| rst | input | 1 | Synchronous active-high reset |
| cfg_cpol | input | 1 | Idle clock level |
| cfg_cpha | input | 1 | Clock phase select |
| cfg_lsb_first | input | 1 | 1: least significant bit first |
| cfg_cs_active_high | input | 1 | Chip-select active level |
| cfg_len_m1 | input | 5 | Word length minus one |
| spi_sck | input | 1 | Bus serial clock |
| spi_mosi | input | 1 | Controller-to-peripheral data |
| spi_miso | input | 1 | Peripheral-to-controller data |
| spi_cs | input | 1 | Bus chip select |
| word_valid | output | 1 | One-cycle strobe for a completed word |
| word_mosi | output | 32 | Completed controller-to-peripheral word |
| word_miso | output | 32 | Completed peripheral-to-controller word |
| word_t_first | output | 32 | Sample counter value at the first bit |
| word_t_last | output | 32 | Sample counter value at the last bit |
| word_count | output | 16 | Number of completed words |

## Verification
Completing a word and the chip select going inactive can land on the same synchronised sample. The bench provokes this by raising the final capturing clock edge and releasing the chip select at the same drive instant. The inactive chip select must win: no strobe appears, the count stays put, and the following word is rebuilt from bit 0. A one-bit word length also makes the first-bit and last-bit stamps fall in the same cycle, and the reference model, which is compared on every clock, must see the two stamps equal.

// File: rtl/spi_mon_pkg.sv
package spi_mon_pkg;
  typedef enum logic [1:0] {
    PH_MODE0 = 2'd0,
    PH_MODE1 = 2'd1,
    PH_MODE2 = 2'd2,
    PH_MODE3 = 2'd3
  } phase_mode_e;

  function automatic phase_mode_e mode_of(input logic pol, input logic pha);
    return phase_mode_e'({pol, pha});
  endfunction

  // Level the clock must reach for a capture in the given mode.
  function automatic logic capture_level(input phase_mode_e m);
    return (m == PH_MODE0) || (m == PH_MODE3);
  endfunction
endpackage

// File: rtl/spi_mon_sync.sv
module spi_mon_sync #(
  parameter int W = 4,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk) begin
    if (rst) stg <= {STAGES{RST_VAL}};
    else     stg <= {stg[STAGES-2:0], d};
  end

  assign q = stg[STAGES-1];

  p_sync_delay_r10: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> stg[1] == $past(stg[0]));
endmodule

// File: rtl/spi_mon_edge.sv
module spi_mon_edge
  import spi_mon_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic sck_s,
  input  logic cpol,
  input  logic cpha,
  output logic cap
);
  logic prev_q;
  phase_mode_e mode;

  assign mode = mode_of(cpol, cpha);
  assign cap  = (sck_s != prev_q) && (sck_s == capture_level(mode));

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sck_s;
  end

  p_cap_on_change_r2: assert property (@(posedge clk) disable iff (rst)
    cap |-> !$stable(sck_s));
endmodule

// File: rtl/spi_mon_shift.sv
module spi_mon_shift #(
  parameter int MAX_W = 32,
  parameter int TS_W  = 32,
  localparam int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             active,
  input  logic             cap,
  input  logic             lsb_first,
  input  logic [LEN_W-1:0] len_m1,
  input  logic             mosi,
  input  logic             miso,
  input  logic [TS_W-1:0]  ts,
  output logic             fin,
  output logic             done,
  output logic [MAX_W-1:0] out_mosi,
  output logic [MAX_W-1:0] out_miso,
  output logic [TS_W-1:0]  out_t_first,
  output logic [TS_W-1:0]  out_t_last
);
  logic [LEN_W-1:0] idx_q, pos;
  logic [MAX_W-1:0] mo_q, mi_q, mo_nx, mi_nx;
  logic [TS_W-1:0]  tf_q;
  logic             last;

  always_comb begin
    pos   = lsb_first ? idx_q : (len_m1 - idx_q);
    mo_nx = mo_q;
    mi_nx = mi_q;
    mo_nx[pos] = mosi;
    mi_nx[pos] = miso;
  end

  assign last = (idx_q >= len_m1);
  assign fin  = active && cap && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx_q       <= '0;
      mo_q        <= '0;
      mi_q        <= '0;
      tf_q        <= '0;
      done        <= 1'b0;
      out_mosi    <= '0;
      out_miso    <= '0;
      out_t_first <= '0;
      out_t_last  <= '0;
    end else begin
      done <= 1'b0;
      if (!active) begin
        idx_q <= '0;
        mo_q  <= '0;
        mi_q  <= '0;
      end else if (cap) begin
        if (last) begin
          done        <= 1'b1;
          out_mosi    <= mo_nx;
          out_miso    <= mi_nx;
          out_t_first <= (idx_q == '0) ? ts : tf_q;
          out_t_last  <= ts;
          idx_q       <= '0;
          mo_q        <= '0;
          mi_q        <= '0;
        end else begin
          if (idx_q == '0) tf_q <= ts;
          idx_q <= idx_q + 1'b1;
          mo_q  <= mo_nx;
          mi_q  <= mi_nx;
        end
      end
    end
  end

  p_idle_clear_r9: assert property (@(posedge clk) disable iff (rst)
    !active |=> (idx_q == '0) && (mo_q == '0) && (mi_q == '0));
  p_stamp_order_r7: assert property (@(posedge clk) disable iff (rst)
    done |-> out_t_first <= out_t_last);
  p_no_done_idle_r9: assert property (@(posedge clk) disable iff (rst)
    !active |=> !done);
endmodule

// File: rtl/spi_mon.sv
module spi_mon #(
  parameter int MAX_W = 32,
  parameter int TS_W  = 32,
  parameter int CNT_W = 16,
  localparam int LEN_W = $clog2(MAX_W)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cfg_cpol,
  input  logic             cfg_cpha,
  input  logic             cfg_lsb_first,
  input  logic             cfg_cs_active_high,
  input  logic [LEN_W-1:0] cfg_len_m1,
  input  logic             spi_sck,
  input  logic             spi_mosi,
  input  logic             spi_miso,
  input  logic             spi_cs,
  output logic             word_valid,
  output logic [MAX_W-1:0] word_mosi,
  output logic [MAX_W-1:0] word_miso,
  output logic [TS_W-1:0]  word_t_first,
  output logic [TS_W-1:0]  word_t_last,
  output logic [CNT_W-1:0] word_count
);
  logic [3:0]      bus_s;
  logic            sck_s, cs_s, mosi_s, miso_s;
  logic            cap, active, fin;
  logic [TS_W-1:0] ts_q;

  spi_mon_sync #(.W(4), .STAGES(2), .RST_VAL(4'b1100)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({spi_sck, spi_cs, spi_mosi, spi_miso}),
    .q   (bus_s)
  );
  assign {sck_s, cs_s, mosi_s, miso_s} = bus_s;
  assign active = (cs_s == cfg_cs_active_high);

  spi_mon_edge u_edge (
    .clk   (clk),
    .rst   (rst),
    .sck_s (sck_s),
    .cpol  (cfg_cpol),
    .cpha  (cfg_cpha),
    .cap   (cap)
  );

  spi_mon_shift #(.MAX_W(MAX_W), .TS_W(TS_W)) u_shift (
    .clk         (clk),
    .rst         (rst),
    .active      (active),
    .cap         (cap),
    .lsb_first   (cfg_lsb_first),
    .len_m1      (cfg_len_m1),
    .mosi        (mosi_s),
    .miso        (miso_s),
    .ts          (ts_q),
    .fin         (fin),
    .done        (word_valid),
    .out_mosi    (word_mosi),
    .out_miso    (word_miso),
    .out_t_first (word_t_first),
    .out_t_last  (word_t_last)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ts_q       <= '0;
      word_count <= '0;
    end else begin
      ts_q <= ts_q + 1'b1;
      if (fin) word_count <= word_count + 1'b1;
    end
  end

  p_ts_step_r7: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> ts_q == $past(ts_q) + 1'b1);
  p_count_step_r8: assert property (@(posedge clk) disable iff (rst)
    word_valid |-> word_count == $past(word_count) + 1'b1);
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    word_valid |=> !word_valid);
  p_count_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !word_valid && !$past(rst) |-> $stable(word_count));
endmodule

// File: tb/sim_spi_mon.sv
module sim_spi_mon;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #4 clk = ~clk;

  logic cpol = 0, cpha = 0, lsb = 0, cs_hi = 0;
  logic [4:0] len_m1 = 5'd7;
  logic sck = 1, mosi = 0, miso = 0, cs = 1;

  logic        w_valid;
  logic [31:0] w_mosi, w_miso, w_tf, w_tl;
  logic [15:0] w_cnt;

  spi_mon u0 (
    .clk(clk), .rst(rst), .cfg_cpol(cpol), .cfg_cpha(cpha),
    .cfg_lsb_first(lsb), .cfg_cs_active_high(cs_hi), .cfg_len_m1(len_m1),
    .spi_sck(sck), .spi_mosi(mosi), .spi_miso(miso), .spi_cs(cs),
    .word_valid(w_valid), .word_mosi(w_mosi), .word_miso(w_miso),
    .word_t_first(w_tf), .word_t_last(w_tl), .word_count(w_cnt)
  );

  int checks = 0, fails = 0, cycles = 0;
  bit done_flag = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Behavioural reference model
  bit h_sck[2], h_cs[2], h_mo[2], h_mi[2];
  bit m_prev;
  int m_idx;
  longint unsigned m_ts;
  bit [31:0] m_wmo, m_wmi, m_tf;
  bit        e_valid;
  bit [31:0] e_mo, e_mi, e_tf, e_tl;
  bit [15:0] e_cnt;

  always @(posedge clk) begin
    if (rst) begin
      h_sck = '{1, 1}; h_cs = '{1, 1}; h_mo = '{0, 0}; h_mi = '{0, 0};
      m_prev = 1; m_idx = 0; m_ts = 0; m_wmo = 0; m_wmi = 0; m_tf = 0;
      e_valid = 0; e_mo = 0; e_mi = 0; e_tf = 0; e_tl = 0; e_cnt = 0;
    end else begin
      bit ls, lc, lmo, lmi, act;
      int len, pos;
      ls = h_sck[0]; lc = h_cs[0]; lmo = h_mo[0]; lmi = h_mi[0];
      len = int'(len_m1) + 1;
      act = (lc == cs_hi);
      e_valid = 0;
      if (act && ls != m_prev && ls == (cpol == cpha)) begin
        pos = lsb ? m_idx : len - 1 - m_idx;
        if (m_idx == 0) m_tf = m_ts[31:0];
        m_wmo[pos] = lmo; m_wmi[pos] = lmi;
        m_idx++;
        if (m_idx >= len) begin
          e_valid = 1; e_mo = m_wmo; e_mi = m_wmi; e_tf = m_tf; e_tl = m_ts[31:0];
          e_cnt++; m_idx = 0; m_wmo = 0; m_wmi = 0;
        end
      end
      m_prev = ls;
      if (!act) begin m_idx = 0; m_wmo = 0; m_wmi = 0; end
      m_ts++;
      h_sck[0] = h_sck[1]; h_sck[1] = sck;
      h_cs[0]  = h_cs[1];  h_cs[1]  = cs;
      h_mo[0]  = h_mo[1];  h_mo[1]  = mosi;
      h_mi[0]  = h_mi[1];  h_mi[1]  = miso;
    end
  end

  // Per-cycle comparison and capture of reported words
  bit [31:0] got_mo, got_mi, got_tf, got_tl;
  always @(negedge clk) begin
    if (!rst && !done_flag) begin
      chk("R6 valid", {63'd0, w_valid}, {63'd0, e_valid});
      chk("R8 count", {48'd0, w_cnt}, {48'd0, e_cnt});
      chk("R3 mosi word", {32'd0, w_mosi}, {32'd0, e_mo});
      chk("R5 miso word", {32'd0, w_miso}, {32'd0, e_mi});
      chk("R7 stamps", {w_tf, w_tl}, {e_tf, e_tl});
      if (w_valid) begin got_mo = w_mosi; got_mi = w_miso; got_tf = w_tf; got_tl = w_tl; end
    end
  end

  localparam int H = 2;

  task automatic waitc(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic setup(input bit pol, input bit pha, input bit lf, input int n);
    @(negedge clk);
    cpol = pol; cpha = pha; lsb = lf; len_m1 = 5'(n - 1); sck = pol;
    waitc(4);
  endtask

  task automatic send_bits(input logic [31:0] mo, input logic [31:0] mi, input int n, input int nbits);
    for (int b = 0; b < nbits; b++) begin
      int ix;
      ix = lsb ? b : n - 1 - b;
      if (!cpha) begin
        mosi = mo[ix]; miso = mi[ix];
        waitc(H); sck = ~sck; waitc(H); sck = ~sck;
      end else begin
        sck = ~sck; mosi = mo[ix]; miso = mi[ix];
        waitc(H); sck = ~sck; waitc(H);
      end
    end
  endtask

  task automatic word(input logic [31:0] mo, input logic [31:0] mi, input int n);
    cs = cs_hi; waitc(3);
    send_bits(mo, mi, n, n);
    waitc(H); cs = ~cs_hi; waitc(6);
  endtask

  initial begin
    bit [15:0] c0;
    waitc(5);
    @(negedge clk); rst = 0;
    chk("R1 valid", {63'd0, w_valid}, 64'd0);
    chk("R1 count", {48'd0, w_cnt}, 64'd0);
    chk("R1 words", {w_mosi, w_miso}, 64'd0);
    chk("R1 stamps", {w_tf, w_tl}, 64'd0);

    // R3 R5 mode 0 MSB first, 8 bits
    setup(0, 0, 0, 8);
    word(32'hA5, 32'h3C, 8);
    chk("R3 mode0 mosi", {32'd0, got_mo}, 64'hA5);
    chk("R5 mode0 miso", {32'd0, got_mi}, 64'h3C);
    chk("R8 count one", {48'd0, w_cnt}, 64'd1);
    chk("R7 span", {32'd0, got_tl - got_tf}, 64'(7 * 2 * H));

    // R4 R2 mode 1 LSB first, 12 bits
    setup(0, 1, 1, 12);
    word(32'hABC, 32'h123, 12);
    chk("R4 lsb mosi", {32'd0, got_mo}, 64'hABC);
    chk("R4 lsb miso", {32'd0, got_mi}, 64'h123);

    // R6 mode 2, 32 bits
    setup(1, 0, 0, 32);
    word(32'hDEADBEEF, 32'h12345678, 32);
    chk("R6 len32 mosi", {32'd0, got_mo}, 64'hDEADBEEF);
    chk("R6 len32 miso", {32'd0, got_mi}, 64'h12345678);

    // R6 R7 mode 3, 1-bit words
    setup(1, 1, 0, 1);
    c0 = w_cnt;
    cs = cs_hi; waitc(3);
    send_bits(32'h1, 32'h0, 1, 1);
    send_bits(32'h0, 32'h1, 1, 1);
    waitc(H); cs = ~cs_hi; waitc(6);
    chk("R6 two 1-bit words", {48'd0, w_cnt}, {48'd0, c0 + 16'd2});
    chk("R7 equal stamps", {32'd0, got_tf}, {32'd0, got_tl});
    chk("R6 1-bit miso", {32'd0, got_mi}, 64'h1);

    // R9 aborted partial word is discarded
    setup(0, 0, 0, 8);
    c0 = w_cnt;
    cs = cs_hi; waitc(3);
    send_bits(32'hFF, 32'hFF, 8, 3);
    cs = ~cs_hi; waitc(6);
    chk("R9 abort no word", {48'd0, w_cnt}, {48'd0, c0});
    word(32'h5A, 32'h96, 8);
    chk("R9 after abort", {32'd0, got_mo}, 64'h5A);

    // R9 same-sample: final capture edge and deselect together
    setup(0, 0, 0, 4);
    c0 = w_cnt;
    cs = cs_hi; waitc(3);
    send_bits(32'hF, 32'hF, 4, 3);
    mosi = 1; miso = 1; waitc(H);
    sck = 1; cs = ~cs_hi; waitc(6);
    sck = 0; waitc(4);
    chk("R9 same sample", {48'd0, w_cnt}, {48'd0, c0});
    word(32'h9, 32'h6, 4);
    chk("R9 restart bit0", {32'd0, got_mo}, 64'h9);

    // R9 active-high chip select
    @(negedge clk); cs_hi = 1; cs = 0;
    setup(0, 0, 0, 8);
    word(32'h81, 32'h7E, 8);
    chk("R9 cs high mosi", {32'd0, got_mo}, 64'h81);
    @(negedge clk); cs_hi = 0; cs = 1; waitc(4);

    // R2 data toggling with steady clock captures nothing
    setup(0, 0, 0, 8);
    c0 = w_cnt;
    cs = cs_hi; waitc(3);
    for (int i = 0; i < 10; i++) begin mosi = ~mosi; miso = ~miso; waitc(1); end
    send_bits(32'hC3, 32'h24, 8, 8);
    waitc(H); cs = ~cs_hi; waitc(6);
    chk("R2 noise ignored", {32'd0, got_mo}, 64'hC3);
    chk("R10 R8 one word", {48'd0, w_cnt}, {48'd0, c0 + 16'd1});

    done_flag = 1;
    $display("  [TB] %0d tests run, %0d failed", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done_flag) begin
      done_flag = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected=<100000", cycles);
      $display("  [TB] %0d tests run, %0d failed", checks, fails);
      $finish;
    end
  end
endmodule